// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Receiver with Sticky Framing-Error Flag

This block is the receive half of a small serial port that runs in the 9-bit asynchronous modes. A frame is a low start bit, eight data bits sent least-significant first, a ninth bit, and a high stop bit. The line is sampled on a 16x oversampling enable. Each bit is decided by a majority vote of three samples taken around its middle. A received byte goes into a data buffer and its ninth bit goes into a control-register bit. A receive-done flag then tells software that a frame is waiting.

Software drives the port through one 8-bit control register. Bit 7 of that register has two meanings, chosen by the `err_view_en` input. With the input low, bit 7 is the upper mode-select bit. With it high, bit 7 is a sticky framing-error flag that hardware sets and only software clears. The same input also moves the point at which the receive-done flag rises: the middle of the ninth bit when error checking is off, and the middle of the stop bit when it is on.

An address-filter bit lets a node ignore every frame whose ninth bit is 0, so that it only wakes on address frames. While the receive-done flag is still set, newly completed frames are dropped.

Top module: `ninebit_serial_rx`

## Requirements
- R1: After a synchronous reset, every control-register bit is 0 under either bit-7 view, `rx_data` is 0, `rx_done` is 0, and the receiver is idle.
- R2: The control-register bits are: bit 7 = mode-high or error flag, 6 = mode-low, 5 = address filter, 4 = receive enable, 3 = transmit ninth bit, 2 = received ninth bit, 1 = transmit done, 0 = receive done. When `err_view_en` is 0, bit 7 reads and writes the mode-high bit. When it is 1, bit 7 reads and writes the error flag. The bit that is not in view keeps its value. Bits 6..0 read back what was last written, unless hardware has updated them.
- R3: The receiver accepts frames only when receive enable (bit 4) is 1 and mode-high is 1 (one of the 9-bit modes). Otherwise, line activity leaves every flag and the buffer unchanged.
- R4: Data bits arrive LSB first. The eight data bits are loaded into `rx_data` and the ninth bit is loaded into bit 2.
- R5: A falling edge whose mid-bit majority vote reads 1 is a false start. The receiver returns to idle, raises no flag, and still receives the next valid frame.
- R6: The error flag is set when the stop bit is voted 0. This happens whether or not the frame is accepted, and in either view. A later valid stop bit does not clear the flag, and a write with `err_view_en` = 0 does not change it. Only writing 0 to bit 7 with `err_view_en` = 1 clears it.
- R7: Consider `sample_tick` held high, with the start edge applied at clock k = 0 (inputs change between rising edges). `rx_done` first reads 1 at k = 158 when `err_view_en` = 0, and at k = 174 when `err_view_en` = 1.
- R8: With the address filter (bit 5) set, a frame whose ninth bit is 0 is discarded: `rx_done`, bit 2 and `rx_data` are unchanged. With the filter set, a frame whose ninth bit is 1 is accepted.
- R9: If `rx_done` is still 1 when a frame completes, that frame is dropped: `rx_data` and bit 2 keep the earlier frame. Once software clears bit 0, the next frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | 16x oversampling enable |
| rxd | input | 1 | Serial line, idles high |
| err_view_en | input | 1 | Selects the error-flag view of bit 7 and late receive-done timing |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_wdata | input | 8 | Control-register write data |
| ctl_rdata | output | 8 | Control-register read data |
| rx_data | output | 8 | Received data buffer |
| rx_done | output | 1 | Receive-done flag (control bit 0) |

## Verification
The bench measures the exact clock on which receive-done rises, in both views. A design that raises the flag at the wrong bit, or one sample early or late, misses the expected count by 16 or by 1. It checks that the error flag survives a clean frame and a write made in the mode view; a design that clears it in either case loses the flag. It sends filtered address frames, false starts, and a frame that arrives while receive-done is still set. These catch a design that overwrites the buffer, raises the flag on a rejected frame, or locks up after a short glitch.

// File: rtl/nbrx_pkg.sv
package nbrx_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FRAME = 1'b1
  } rx_state_t;

  localparam int CTL_W       = 8;
  localparam int B_HI_OR_ERR = 7;
  localparam int B_MODE_LO   = 6;
  localparam int B_ADDR_FILT = 5;
  localparam int B_RX_EN     = 4;
  localparam int B_TX_NINTH  = 3;
  localparam int B_RX_NINTH  = 2;
  localparam int B_TX_DONE   = 1;
  localparam int B_RX_DONE   = 0;
endpackage

// File: rtl/nbrx_sampler.sv
module nbrx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rxd,
  output logic s_level,
  output logic fall
);
  logic prev_q;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], rxd};
      end
      assign s_level = chain_q[SYNC_STAGES-1];
    end else begin : g_single
      logic one_q;
      always_ff @(posedge clk) begin
        if (rst) one_q <= 1'b1;
        else     one_q <= rxd;
      end
      assign s_level = one_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       prev_q <= 1'b1;
    else if (tick) prev_q <= s_level;
  end

  assign fall = tick && prev_q && !s_level;
endmodule

// File: rtl/nbrx_frame.sv
module nbrx_frame
  import nbrx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 enable,
  input  logic                 early,
  input  logic                 s_level,
  input  logic                 fall,
  output logic                 load_q,
  output logic                 stop_bad_q,
  output logic [DATA_BITS-1:0] shift_q,
  output logic                 ninth_q
);
  localparam int SUB_W     = $clog2(OVS);
  localparam int IDX_W     = $clog2(DATA_BITS + 3);
  localparam int MID       = OVS / 2;
  localparam int NINTH_IDX = DATA_BITS + 1;
  localparam int STOP_IDX  = DATA_BITS + 2;

  rx_state_t        state_q;
  logic [SUB_W-1:0] sub_q;
  logic [IDX_W-1:0] idx_q;
  logic             vote_a_q, vote_b_q;
  logic             bit_val;

  assign bit_val = (vote_a_q & vote_b_q) | (vote_a_q & s_level) | (vote_b_q & s_level);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sub_q      <= '0;
      idx_q      <= '0;
      vote_a_q   <= 1'b1;
      vote_b_q   <= 1'b1;
      shift_q    <= '0;
      ninth_q    <= 1'b0;
      load_q     <= 1'b0;
      stop_bad_q <= 1'b0;
    end else begin
      load_q     <= 1'b0;
      stop_bad_q <= 1'b0;
      if (!enable) begin
        state_q <= ST_IDLE;
      end else if (tick) begin
        case (state_q)
          ST_IDLE: begin
            if (fall) begin
              state_q <= ST_FRAME;
              sub_q   <= '0;
              idx_q   <= '0;
            end
          end
          ST_FRAME: begin
            if (sub_q == SUB_W'(OVS - 1)) begin
              sub_q <= '0;
              idx_q <= idx_q + IDX_W'(1);
            end else begin
              sub_q <= sub_q + SUB_W'(1);
            end
            if (sub_q == SUB_W'(MID - 1)) vote_a_q <= s_level;
            if (sub_q == SUB_W'(MID))     vote_b_q <= s_level;
            if (sub_q == SUB_W'(MID + 1)) begin
              if (idx_q == '0) begin
                if (bit_val) state_q <= ST_IDLE;
              end else if (idx_q <= IDX_W'(DATA_BITS)) begin
                shift_q <= {bit_val, shift_q[DATA_BITS-1:1]};
              end else if (idx_q == IDX_W'(NINTH_IDX)) begin
                ninth_q <= bit_val;
                if (early) load_q <= 1'b1;
              end else begin
                stop_bad_q <= !bit_val;
                if (!early) load_q <= 1'b1;
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: a disabled receiver drops back to idle on the next edge
  assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    !enable |=> state_q == ST_IDLE);

  // R4: the bit index never walks past the stop bit
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_FRAME |-> idx_q <= IDX_W'(STOP_IDX));

  // R7: a load pulse comes from the ninth bit or the stop bit, per the view
  assert_load_point_R7: assert property (@(posedge clk) disable iff (rst)
    load_q |-> $past(idx_q) == ($past(early) ? IDX_W'(NINTH_IDX) : IDX_W'(STOP_IDX)));
endmodule

// File: rtl/nbrx_ctlreg.sv
module nbrx_ctlreg
  import nbrx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 err_view_en,
  input  logic                 ctl_we,
  input  logic [CTL_W-1:0]     ctl_wdata,
  input  logic                 frame_load,
  input  logic                 frame_ninth,
  input  logic [DATA_BITS-1:0] frame_data,
  input  logic                 stop_bad,
  output logic [CTL_W-1:0]     ctl_rdata,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 mode_hi,
  output logic                 rx_en
);
  logic mode_hi_q, err_q, mode_lo_q, filt_q, en_q, tx9_q, rx9_q, txd_q, rxd_q;
  logic [DATA_BITS-1:0] buf_q;
  logic accept;

  assign accept = frame_load && !rxd_q && !(filt_q && !frame_ninth);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_hi_q <= 1'b0;
      err_q     <= 1'b0;
      mode_lo_q <= 1'b0;
      filt_q    <= 1'b0;
      en_q      <= 1'b0;
      tx9_q     <= 1'b0;
      rx9_q     <= 1'b0;
      txd_q     <= 1'b0;
      rxd_q     <= 1'b0;
      buf_q     <= '0;
    end else begin
      if (ctl_we) begin
        if (err_view_en) err_q     <= ctl_wdata[B_HI_OR_ERR];
        else             mode_hi_q <= ctl_wdata[B_HI_OR_ERR];
        mode_lo_q <= ctl_wdata[B_MODE_LO];
        filt_q    <= ctl_wdata[B_ADDR_FILT];
        en_q      <= ctl_wdata[B_RX_EN];
        tx9_q     <= ctl_wdata[B_TX_NINTH];
        rx9_q     <= ctl_wdata[B_RX_NINTH];
        txd_q     <= ctl_wdata[B_TX_DONE];
        rxd_q     <= ctl_wdata[B_RX_DONE];
      end
      if (stop_bad) err_q <= 1'b1;
      if (accept) begin
        buf_q <= frame_data;
        rx9_q <= frame_ninth;
        rxd_q <= 1'b1;
      end
    end
  end

  assign ctl_rdata = {err_view_en ? err_q : mode_hi_q, mode_lo_q, filt_q, en_q,
                      tx9_q, rx9_q, txd_q, rxd_q};
  assign rx_data   = buf_q;
  assign mode_hi   = mode_hi_q;
  assign rx_en     = en_q;

  // R6: the error flag only falls through a clearing write in the error view
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    err_q && !(ctl_we && err_view_en && !ctl_wdata[B_HI_OR_ERR]) |=> err_q);

  // R9: a pending receive-done flag freezes the buffer
  assert_buf_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    rxd_q |=> $stable(buf_q));

  // R9: receive-done holds until software writes it low
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
    rxd_q && !(ctl_we && !ctl_wdata[B_RX_DONE]) |=> rxd_q);

  // R8: with filtering on, a hardware-raised done flag always comes with ninth bit 1
  assert_filter_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rxd_q) && !$past(ctl_we) && $past(filt_q) |-> rx9_q);
endmodule

// File: rtl/ninebit_serial_rx.sv
module ninebit_serial_rx
  import nbrx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_tick,
  input  logic                 rxd,
  input  logic                 err_view_en,
  input  logic                 ctl_we,
  input  logic [CTL_W-1:0]     ctl_wdata,
  output logic [CTL_W-1:0]     ctl_rdata,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_done
);
  logic s_level, fall;
  logic load, stop_bad, ninth;
  logic [DATA_BITS-1:0] shift;
  logic mode_hi, rx_en;

  nbrx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .tick(sample_tick), .rxd(rxd),
    .s_level(s_level), .fall(fall)
  );

  nbrx_frame #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_frame (
    .clk(clk), .rst(rst), .tick(sample_tick),
    .enable(rx_en && mode_hi), .early(!err_view_en),
    .s_level(s_level), .fall(fall),
    .load_q(load), .stop_bad_q(stop_bad), .shift_q(shift), .ninth_q(ninth)
  );

  nbrx_ctlreg #(.DATA_BITS(DATA_BITS)) u_ctl (
    .clk(clk), .rst(rst), .err_view_en(err_view_en),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .frame_load(load), .frame_ninth(ninth), .frame_data(shift), .stop_bad(stop_bad),
    .ctl_rdata(ctl_rdata), .rx_data(rx_data), .mode_hi(mode_hi), .rx_en(rx_en)
  );

  assign rx_done = ctl_rdata[B_RX_DONE];
endmodule

// File: tb/tb_ninebit_serial_rx.sv
module tb_ninebit_serial_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_tick = 1'b1;
  logic rxd = 1'b1;
  logic err_view_en = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic [7:0] rx_data;
  logic rx_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ninebit_serial_rx dut (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .rxd(rxd),
    .err_view_en(err_view_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .rx_data(rx_data), .rx_done(rx_done)
  );

  // {view, filter, ninth, stop, data[7:0], done_code[1:0], err_expected}
  // done_code: 0 = dropped, 1 = raised at k=158, 2 = raised at k=174
  localparam logic [14:0] VEC [0:7] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 2'd1, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 2'd2, 1'b0},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 2'd2, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h7E, 2'd1, 1'b1},
    {1'b0, 1'b1, 1'b0, 1'b1, 8'h11, 2'd0, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'hC3, 2'd2, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h55, 2'd0, 1'b1},
    {1'b0, 1'b1, 1'b1, 1'b1, 8'hF0, 2'd1, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  function automatic logic frame_bit(input int k, input logic [7:0] d,
                                     input logic n, input logic s);
    int idx;
    idx = k / 16;
    if (idx == 0) return 1'b0;
    if (idx <= 8) return d[idx-1];
    if (idx == 9) return n;
    if (idx == 10) return s;
    return 1'b1;
  endfunction

  // returns the clock index k at which rx_done first read 1, or -1
  task automatic send_frame(input logic [7:0] d, input logic n, input logic s,
                            output int done_at);
    done_at = -1;
    for (int k = 0; k < 180; k++) begin
      @(negedge clk);
      if (done_at < 0 && rx_done) done_at = k;
      rxd = frame_bit(k, d, n, s);
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // set mode-high, receive enable and filter, clear flags and the error bit
  task automatic setup(input logic view, input logic filt);
    err_view_en = 1'b0;
    wr({1'b1, 1'b0, filt, 1'b1, 4'b0000});
    err_view_en = 1'b1;
    wr({1'b0, 1'b0, filt, 1'b1, 4'b0000});
    err_view_en = view;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog act=timeout exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    int done_at;
    logic [7:0] exp_data;
    exp_data = 8'h00;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 rdata mode view", ctl_rdata, 8'h00);
    err_view_en = 1'b1;
    @(negedge clk);
    check("R1 rdata error view", ctl_rdata, 8'h00);
    check("R1 rx_data", rx_data, 8'h00);
    check("R1 rx_done", rx_done, 0);

    // R2: bit 7 view selection, other bits read back
    err_view_en = 1'b0;
    wr(8'h7A);
    check("R2 readback mode view", ctl_rdata, 8'h7A);
    err_view_en = 1'b1;
    wr(8'hFA);
    check("R2 error flag written", ctl_rdata, 8'hFA);
    err_view_en = 1'b0;
    @(negedge clk);
    check("R2 mode-high kept", ctl_rdata, 8'h7A);
    wr(8'h00);
    err_view_en = 1'b1;
    @(negedge clk);
    check("R2 error flag kept", ctl_rdata, 8'h80);
    wr(8'h00);
    check("R2 error flag cleared", ctl_rdata, 8'h00);

    // R3: receiver off without enable or without mode-high
    err_view_en = 1'b0;
    wr(8'h80);
    send_frame(8'hA5, 1'b1, 1'b1, done_at);
    check("R3 no enable done", done_at, -1);
    check("R3 no enable data", rx_data, 8'h00);
    wr(8'h50);
    send_frame(8'hA5, 1'b1, 1'b1, done_at);
    check("R3 mode-high 0 done", done_at, -1);
    check("R3 mode-high 0 data", rx_data, 8'h00);

    // vector table: R4, R6, R7, R8
    for (int i = 0; i < 8; i++) begin
      logic v_view, v_filt, v_n, v_s, v_err;
      logic [7:0] v_d;
      logic [1:0] v_code;
      {v_view, v_filt, v_n, v_s, v_d, v_code, v_err} = VEC[i];
      setup(v_view, v_filt);
      send_frame(v_d, v_n, v_s, done_at);
      if (v_code == 2'd0) begin
        check($sformatf("R8 vec%0d done", i), done_at, -1);
        check($sformatf("R8 vec%0d data", i), rx_data, exp_data);
        check($sformatf("R8 vec%0d ninth", i), ctl_rdata[2], 0);
      end else begin
        exp_data = v_d;
        check($sformatf("R7 vec%0d done cycle", i), done_at, (v_code == 2'd1) ? 158 : 174);
        check($sformatf("R4 vec%0d data", i), rx_data, exp_data);
        check($sformatf("R4 vec%0d ninth", i), ctl_rdata[2], v_n);
      end
      err_view_en = 1'b1;
      @(negedge clk);
      check($sformatf("R6 vec%0d error flag", i), ctl_rdata[7], v_err);
    end

    // R5: false start, then a valid frame
    setup(1'b0, 1'b0);
    @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    check("R5 false start done", rx_done, 0);
    check("R5 false start data", rx_data, exp_data);
    send_frame(8'h96, 1'b1, 1'b1, done_at);
    check("R5 recovery done cycle", done_at, 158);
    check("R5 recovery data", rx_data, 8'h96);

    // R6: stickiness across a clean frame and a mode-view write
    setup(1'b1, 1'b0);
    send_frame(8'h2B, 1'b1, 1'b0, done_at);
    check("R6 bad stop sets flag", ctl_rdata[7], 1);
    err_view_en = 1'b0;
    wr(8'h90);
    send_frame(8'h4D, 1'b1, 1'b1, done_at);
    check("R6 clean frame received", rx_data, 8'h4D);
    err_view_en = 1'b1;
    @(negedge clk);
    check("R6 flag survives clean stop", ctl_rdata[7], 1);
    err_view_en = 1'b0;
    wr(8'h80);
    err_view_en = 1'b1;
    @(negedge clk);
    check("R6 flag survives mode write", ctl_rdata[7], 1);
    wr(8'h10);
    check("R6 flag cleared by write", ctl_rdata[7], 0);

    // R9: frame arriving while done is still set
    setup(1'b0, 1'b0);
    send_frame(8'h3A, 1'b1, 1'b1, done_at);
    check("R9 first frame data", rx_data, 8'h3A);
    send_frame(8'hC5, 1'b0, 1'b1, done_at);
    check("R9 held data", rx_data, 8'h3A);
    check("R9 held ninth", ctl_rdata[2], 1);
    check("R9 done still set", rx_done, 1);
    wr(8'h90);
    send_frame(8'h6B, 1'b1, 1'b1, done_at);
    check("R9 accepted after clear", rx_data, 8'h6B);
    check("R9 done cycle after clear", done_at, 158);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule